// File: doc/BRIEF.md
# Iterative Rotate-Through-Carry Unit

This block rotates a byte or word operand left or right through a carry flag, one bit position per clock cycle, for a count of 0 to 31 steps. The carry acts as one extra bit of the ring. A byte operand therefore turns inside a 9-bit ring, and a word operand inside a 17-bit ring. A host pulses `start` with the operand, the incoming carry, the direction, the size and the count. It then waits for the one-cycle `done` pulse and reads the result, the new carry and the overflow flag.

Overflow is only meaningful for a single-step rotate. In that case it is computed by a rule that depends on the direction, and `ovf_valid` is raised. For every other count `ovf_valid` is low and `ovf` keeps its previous value. The block updates no flag other than carry and overflow.

Top module: `carry_rotate_unit`

## Requirements
- R1: After reset, `result`, `carry_out`, `ovf`, `ovf_valid`, `busy` and `done` are all 0.
- R2: A left step moves the carry into bit 0, shifts the operand up by one and takes the new carry from the old top bit. The top bit is bit 15 in word mode and bit 7 in byte mode.
- R3: A right step moves the carry into the top bit, shifts the operand down by one and takes the new carry from the old bit 0.
- R4: A count of 0 leaves the operand and the carry unchanged, and `done` pulses in the cycle after `start`.
- R5: For a count N accepted at clock edge k, `busy` is high from edge k until edge k+N+1. At edge k+N+1 `busy` falls and `done` is high for exactly one cycle.
- R6: With count 1 and direction left (`dir_right`=0), `ovf` = top bit of the result XOR the final carry, and `ovf_valid` = 1.
- R7: With count 1 and direction right (`dir_right`=1), `ovf` = top bit XOR the next-to-top bit of the result, and `ovf_valid` = 1.
- R8: With any count other than 1, `ovf_valid` = 0 when `done` pulses and `ovf` holds the value from the previous operation.
- R9: In byte mode (`word_mode`=0), `result[15:8]` is 0 and the ring is 9 bits wide. In word mode the ring is 17 bits wide.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The running operation finishes with its own operands and timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| dir_right | input | 1 | 0 = rotate left, 1 = rotate right |
| word_mode | input | 1 | 0 = byte operand, 1 = word operand |
| operand | input | 16 | Value to rotate (low 8 bits used in byte mode) |
| carry_in | input | 1 | Incoming carry flag |
| count | input | 5 | Number of rotate steps, 0 to 31 |
| result | output | 16 | Rotated value |
| carry_out | output | 1 | Updated carry flag |
| ovf | output | 1 | Overflow flag |
| ovf_valid | output | 1 | High when the last operation defined `ovf` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The data register and the carry register are visible at the ports after every operation. A wrong step rule or a wrong ring width therefore shows up as a wrong `result` or `carry_out` at the first `done` of an affected operation. A step counter that is off by one, or that reloads, moves the `done` pulse by at least one cycle. It also changes the number of rotate steps applied, and the bench detects both. A stale one-step marker shows as a wrong `ovf_valid` on the next `done`.

// File: rtl/carry_rot_pkg.sv
package carry_rot_pkg;
  typedef enum logic {
    ROT_LEFT  = 1'b0,
    ROT_RIGHT = 1'b1
  } rot_dir_e;
endpackage

// File: rtl/rot_step.sv
// One rotate step through the carry for a byte or word ring.
module rot_step
  import carry_rot_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] data_i,
  input  logic         cf_i,
  input  rot_dir_e     dir_i,
  input  logic         word_i,
  output logic [W-1:0] data_o,
  output logic         cf_o
);
  localparam int H = W / 2;

  always_comb begin
    if (dir_i == ROT_LEFT) begin
      if (word_i) begin
        cf_o   = data_i[W-1];
        data_o = {data_i[W-2:0], cf_i};
      end else begin
        cf_o   = data_i[H-1];
        data_o = {{H{1'b0}}, data_i[H-2:0], cf_i};
      end
    end else begin
      cf_o = data_i[0];
      if (word_i) data_o = {cf_i, data_i[W-1:1]};
      else        data_o = {{H{1'b0}}, cf_i, data_i[H-1:1]};
    end
  end
endmodule

// File: rtl/rot_ovf.sv
// Overflow rule for a single-step rotate; differs by direction.
module rot_ovf
  import carry_rot_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] data_i,
  input  logic         cf_i,
  input  rot_dir_e     dir_i,
  input  logic         word_i,
  output logic         ovf_o
);
  localparam int H = W / 2;
  logic top_bit, next_bit;

  always_comb begin
    top_bit  = word_i ? data_i[W-1] : data_i[H-1];
    next_bit = word_i ? data_i[W-2] : data_i[H-2];
    ovf_o    = (dir_i == ROT_LEFT) ? (top_bit ^ cf_i) : (top_bit ^ next_bit);
  end
endmodule

// File: rtl/rot_seq.sv
// Step counter and handshake sequencing.
module rot_seq #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             load_o,
  output logic             step_o,
  output logic             finish_o,
  output logic             one_o,
  output logic             busy_o,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, done_q, done_d, one_q, one_d;

  always_comb begin
    load_o   = start_i & ~busy_q;
    step_o   = busy_q & (cnt_q != '0);
    finish_o = busy_q & (cnt_q == '0);
    cnt_d    = cnt_q;
    busy_d   = busy_q;
    one_d    = one_q;
    if (load_o) begin
      cnt_d  = count_i;
      busy_d = 1'b1;
      one_d  = (count_i == CNT_W'(1));
    end else if (step_o) begin
      cnt_d  = cnt_q - 1'b1;
    end else if (finish_o) begin
      busy_d = 1'b0;
    end
    done_d = finish_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      one_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
      one_q  <= one_d;
    end
  end

  assign one_o  = one_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/carry_rotate_unit.sv
module carry_rotate_unit
  import carry_rot_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_right,
  input  logic             word_mode,
  input  logic [W-1:0]     operand,
  input  logic             carry_in,
  input  logic [CNT_W-1:0] count,
  output logic [W-1:0]     result,
  output logic             carry_out,
  output logic             ovf,
  output logic             ovf_valid,
  output logic             busy,
  output logic             done
);
  localparam int H = W / 2;

  logic           load, step, finish, one_cnt;
  logic [W-1:0]   data_q, data_d, step_data;
  logic           cf_q, cf_d, step_cf;
  logic           size_q, size_d;
  rot_dir_e       dir_q, dir_d;
  logic           ovf_q, ovf_d, ovfv_q, ovfv_d, ovf_calc;

  rot_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start), .count_i(count),
    .load_o(load), .step_o(step), .finish_o(finish), .one_o(one_cnt),
    .busy_o(busy), .done_o(done)
  );

  rot_step #(.W(W)) u_step (
    .data_i(data_q), .cf_i(cf_q), .dir_i(dir_q), .word_i(size_q),
    .data_o(step_data), .cf_o(step_cf)
  );

  rot_ovf #(.W(W)) u_ovf (
    .data_i(data_q), .cf_i(cf_q), .dir_i(dir_q), .word_i(size_q),
    .ovf_o(ovf_calc)
  );

  always_comb begin
    data_d = data_q;
    cf_d   = cf_q;
    size_d = size_q;
    dir_d  = dir_q;
    ovf_d  = ovf_q;
    ovfv_d = ovfv_q;
    if (load) begin
      data_d = word_mode ? operand : {{H{1'b0}}, operand[H-1:0]};
      cf_d   = carry_in;
      size_d = word_mode;
      dir_d  = rot_dir_e'(dir_right);
    end else if (step) begin
      data_d = step_data;
      cf_d   = step_cf;
    end
    if (finish) begin
      ovfv_d = one_cnt;
      if (one_cnt) ovf_d = ovf_calc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      cf_q   <= 1'b0;
      size_q <= 1'b0;
      dir_q  <= ROT_LEFT;
      ovf_q  <= 1'b0;
      ovfv_q <= 1'b0;
    end else begin
      data_q <= data_d;
      cf_q   <= cf_d;
      size_q <= size_d;
      dir_q  <= dir_d;
      ovf_q  <= ovf_d;
      ovfv_q <= ovfv_d;
    end
  end

  assign result    = data_q;
  assign carry_out = cf_q;
  assign ovf       = ovf_q;
  assign ovf_valid = ovfv_q;

  // R9
  byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !size_q |-> (data_q[W-1:H] == '0));
  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(size_q) && $stable(dir_q)));
  // R8
  ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ovf_valid) |-> (ovf == $past(ovf)));
  // R4
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && count == '0) |=> ##1 (done && $stable(result) && $stable(carry_out)));
endmodule

// File: tb/tb_carry_rotate_unit.sv
module tb_carry_rotate_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, dir_right = 1'b0, word_mode = 1'b0, carry_in = 1'b0;
  logic [15:0] operand = '0;
  logic [4:0]  count = '0;
  logic [15:0] result;
  logic        carry_out, ovf, ovf_valid, busy, done;

  int checks = 0, fails = 0;
  logic exp_ovf = 1'b0;

  always #10 clk = ~clk;

  carry_rotate_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_right(dir_right),
    .word_mode(word_mode), .operand(operand), .carry_in(carry_in), .count(count),
    .result(result), .carry_out(carry_out), .ovf(ovf), .ovf_valid(ovf_valid),
    .busy(busy), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // returns {carry, data}; R2, R3, R9 ring semantics
  function automatic logic [16:0] model(input logic [15:0] op, input logic cin,
                                         input logic dr, input logic wd, input int n);
    logic [15:0] d;
    logic c, t;
    int msb;
    msb = wd ? 15 : 7;
    d = wd ? op : {8'h00, op[7:0]};
    c = cin;
    for (int i = 0; i < n; i++) begin
      t = c;
      if (!dr) begin
        c = d[msb];
        d = {d[14:0], t};
      end else begin
        c = d[0];
        d = d >> 1;
        d[msb] = t;
      end
      if (!wd) d[15:8] = 8'h00;
    end
    return {c, d};
  endfunction

  task automatic run_op(input logic [15:0] op, input logic cin, input logic dr,
                        input logic wd, input int n, input bit inject, input string tag);
    logic [16:0] m;
    int msb;
    logic e_ovf;
    m = model(op, cin, dr, wd, n);
    msb = wd ? 15 : 7;
    @(negedge clk);
    operand = op; carry_in = cin; dir_right = dr; word_mode = wd; count = 5'(n);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      // R10: a second start while busy must be ignored
      operand = ~op; carry_in = ~cin; dir_right = ~dr; word_mode = ~wd; count = 5'd3;
      start = 1'b1;
    end
    chk({tag, " R5 busy"}, busy, 1);
    for (int i = 0; i < n; i++) begin
      chk({tag, " R5 no early done"}, done, 0);
      @(negedge clk);
      start = 1'b0;
    end
    chk({tag, " R5 done before"}, done, 0);
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R5 done"}, done, 1);
    chk({tag, " R5 busy low"}, busy, 0);
    chk({tag, " R2 R3 result"}, result, m[15:0]);
    chk({tag, " R2 R3 carry"}, carry_out, m[16]);
    if (!wd) chk({tag, " R9 upper zero"}, result[15:8], 0);
    if (n == 1) begin
      e_ovf = dr ? (m[msb] ^ m[msb-1]) : (m[msb] ^ m[16]);
      exp_ovf = e_ovf;
      chk({tag, dr ? " R7 ovf" : " R6 ovf"}, ovf, exp_ovf);
      chk({tag, " R6 R7 ovf_valid"}, ovf_valid, 1);
    end else begin
      chk({tag, " R8 ovf hold"}, ovf, exp_ovf);
      chk({tag, " R8 ovf_valid"}, ovf_valid, 0);
    end
    @(negedge clk);
    chk({tag, " R5 pulse"}, done, 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    #5;
    // R1 reset state
    chk("R1 result", result, 0);
    chk("R1 flags", {carry_out, ovf, ovf_valid, busy, done}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 after release", {result, carry_out, busy, done}, 0);

    run_op(16'h00A5, 1'b1, 1'b0, 1'b0, 0, 0, "R4 zero byte");
    run_op(16'h8001, 1'b0, 1'b1, 1'b1, 0, 0, "R4 zero word");
    run_op(16'h0080, 1'b0, 1'b0, 1'b0, 1, 0, "R2 R6 byte left");
    run_op(16'h4000, 1'b0, 1'b0, 1'b1, 1, 0, "R2 R6 word left");
    run_op(16'h0001, 1'b1, 1'b1, 1'b0, 1, 0, "R3 R7 byte right");
    run_op(16'h0000, 1'b1, 1'b1, 1'b1, 1, 0, "R3 R7 word right");
    run_op(16'h1234, 1'b1, 1'b0, 1'b0, 9, 0, "R9 byte full ring");
    run_op(16'hBEEF, 1'b0, 1'b1, 1'b1, 17, 0, "R9 word full ring");
    run_op(16'hFF5A, 1'b1, 1'b0, 1'b1, 31, 0, "R5 max count");
    run_op(16'h3C3C, 1'b0, 1'b1, 1'b1, 4, 1, "R10 start ignored");
    run_op(16'h00C3, 1'b1, 1'b0, 1'b0, 0, 1, "R10 zero ignored");

    for (int k = 0; k < 300; k++) begin
      logic [31:0] r;
      int n;
      r = $urandom;
      n = (r[7:5] == 3'd0) ? 1 : int'(r[12:8]);
      run_op(r[31:16], r[0], r[1], r[2], n, r[3], "rand R2 R3 R6 R7 R8");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule